// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Driver

The block displays a binary value from 0 to 99 as two decimal digits on a pair of seven-segment displays that share one segment bus. It finds the tens and ones digits by comparing the input against ten decade ranges. It converts each digit to an active-high segment pattern. It then shows the two digits in turn, switching between them on a divided scan tick that is fast enough for the eye to see both lit at once.

One digit-select vector of eight bits chooses which display is lit. Only two positions are ever used, one for the tens digit and one for the ones digit. A leading zero in the tens place is blanked, while the ones place always shows a digit. A value above 99 blanks both displays. A synchronous clear restarts the scan at the tens digit and begins a full slot.

Top module: `dual_digit_display`

## Requirements
- R1: While the asynchronous active-low reset is asserted, `seg_o` is 7'b0000000 and `dig_sel_o` is 8'b00000000.
- R2: While the ones digit is selected and the value is 0 to 99, `seg_o` shows the pattern of value mod 10.
- R3: While the tens digit is selected and the value is 10 to 99, `seg_o` shows the pattern of value div 10.
- R4: Segment bit 6 is a and bit 0 is g, with 1 meaning lit. The patterns are 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111, 7=1110000, 8=1111111 and 9=1110011.
- R5: For values 0 to 9, the tens slot shows 0000000. A ones digit of zero shows the 0 pattern.
- R6: For input values above 99, both slots show 0000000.
- R7: Outside reset, `dig_sel_o` is 8'b00000010 for the tens slot and 8'b00000001 for the ones slot, and never any other value.
- R8: Each slot lasts exactly SCAN_DIV = CLK_HZ/SCAN_HZ clock cycles, and the tens and ones slots alternate.
- R9: A cycle with `clear_i` high selects the tens slot at the next clock edge and starts a full slot.
- R10: `seg_o` and `dig_sel_o` are registered and change on the same edge, so every cycle shows the pattern that belongs to the selected digit.
- R11: A change on `value_i` reaches `seg_o` at the first clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous scan restart at the tens slot |
| value_i | input | 8 | Binary value to display |
| seg_o | output | 7 | Segments a..g, active high, bit 6 = a |
| dig_sel_o | output | 8 | One-hot digit enable |

## Verification
The hardest situation to reach is an input change in the middle of a slot. Here the bench must show that the segments follow the new value one edge later while the enable stays where it is. To reach it, the bench first aligns the scan with `clear_i`, so it knows the exact slot phase. It then changes the value at a known cycle inside the tens slot. Slot length is checked by counting cycles from each clear. Values above 99 and single-digit values are driven both directly and at random, so that the blanking paths run in both slots.

// File: rtl/digit_display_pkg.sv
package digit_display_pkg;

   typedef logic [6:0] seg_t;

   localparam seg_t SEG_DARK = 7'b000_0000;

   typedef enum logic {
      SLOT_TENS = 1'b0,
      SLOT_ONES = 1'b1
   } slot_e;

   // bit 6 = segment a ... bit 0 = segment g, active high
   function automatic seg_t digit_glyph(input logic [3:0] d);
      case (d)
         4'd0:    return 7'b111_1110;
         4'd1:    return 7'b011_0000;
         4'd2:    return 7'b110_1101;
         4'd3:    return 7'b111_1001;
         4'd4:    return 7'b011_0011;
         4'd5:    return 7'b101_1011;
         4'd6:    return 7'b001_1111;
         4'd7:    return 7'b111_0000;
         4'd8:    return 7'b111_1111;
         4'd9:    return 7'b111_0011;
         default: return SEG_DARK;
      endcase
   endfunction

endpackage

// File: rtl/scan_tick.sv
module scan_tick #(
   parameter int unsigned DIV = 50000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   output logic tick_o
);
   localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("scan_tick: DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (clear_i || tick_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/decade_split.sv
module decade_split #(
   parameter int unsigned VALUE_W = 8
) (
   input  logic [VALUE_W-1:0] value_i,
   output logic [3:0]         tens_o,
   output logic [3:0]         ones_o,
   output logic               over_o
);
   localparam int unsigned DECADES = 10;

   if (VALUE_W < 7) begin : g_bad_width
      $error("decade_split: VALUE_W must hold 99");
   end

   logic [DECADES-1:0] in_decade;

   for (genvar g = 0; g < DECADES; g++) begin : g_decade
      assign in_decade[g] = (value_i >= VALUE_W'(g * 10)) &&
                            (value_i <  VALUE_W'(g * 10 + 10));
   end

   always_comb begin
      tens_o = 4'd0;
      ones_o = 4'd0;
      for (int d = 0; d < DECADES; d++) begin
         if (in_decade[d]) begin
            tens_o = 4'(d);
            ones_o = 4'(value_i - VALUE_W'(d * 10));
         end
      end
   end

   assign over_o = ~|in_decade;
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
   import digit_display_pkg::*;
(
   input  logic [3:0] digit_i,
   input  logic       dark_i,
   output seg_t       seg_o
);
   assign seg_o = dark_i ? SEG_DARK : digit_glyph(digit_i);
endmodule

// File: rtl/dual_digit_display.sv
module dual_digit_display
   import digit_display_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned SCAN_HZ    = 1000,
   parameter int unsigned VALUE_W    = 8,
   parameter int unsigned SEL_W      = 8,
   parameter int unsigned TENS_IDX   = 1,
   parameter int unsigned ONES_IDX   = 0,
   parameter bit          LEAD_BLANK = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clear_i,
   input  logic [VALUE_W-1:0] value_i,
   output logic [6:0]         seg_o,
   output logic [SEL_W-1:0]   dig_sel_o
);
   localparam int unsigned SCAN_DIV = CLK_HZ / SCAN_HZ;
   localparam logic [SEL_W-1:0] SEL_TENS = SEL_W'(1) << TENS_IDX;
   localparam logic [SEL_W-1:0] SEL_ONES = SEL_W'(1) << ONES_IDX;

   if (SCAN_DIV < 2) begin : g_bad_rate
      $error("dual_digit_display: CLK_HZ/SCAN_HZ must be at least 2");
   end
   if (TENS_IDX >= SEL_W || ONES_IDX >= SEL_W || TENS_IDX == ONES_IDX) begin : g_bad_sel
      $error("dual_digit_display: digit select indices invalid");
   end

   logic       tick;
   logic [3:0] tens, ones;
   logic       over;
   logic       tens_dark;
   seg_t       tens_seg, ones_seg;

   scan_tick #(.DIV(SCAN_DIV)) i_tick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .tick_o  (tick)
   );

   decade_split #(.VALUE_W(VALUE_W)) i_split (
      .value_i (value_i),
      .tens_o  (tens),
      .ones_o  (ones),
      .over_o  (over)
   );

   if (LEAD_BLANK) begin : g_lead_blank
      assign tens_dark = over || (tens == 4'd0);
   end else begin : g_lead_show
      assign tens_dark = over;
   end

   seg_encoder i_enc_tens (.digit_i(tens), .dark_i(tens_dark), .seg_o(tens_seg));
   seg_encoder i_enc_ones (.digit_i(ones), .dark_i(over),      .seg_o(ones_seg));

   slot_e slot_q, slot_d;

   always_comb begin
      slot_d = slot_q;
      if (clear_i)   slot_d = SLOT_TENS;
      else if (tick) slot_d = (slot_q == SLOT_TENS) ? SLOT_ONES : SLOT_TENS;
   end

   logic [6:0]       seg_q;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_q <= SLOT_TENS;
         seg_q  <= SEG_DARK;
         sel_q  <= '0;
      end else begin
         slot_q <= slot_d;
         seg_q  <= (slot_d == SLOT_TENS) ? tens_seg : ones_seg;
         sel_q  <= (slot_d == SLOT_TENS) ? SEL_TENS : SEL_ONES;
      end
   end

   assign seg_o     = seg_q;
   assign dig_sel_o = sel_q;
endmodule

// File: rtl/dual_digit_display_checker.sv
module dual_digit_display_checker #(
   parameter int unsigned      VALUE_W    = 8,
   parameter int unsigned      SEL_W      = 8,
   parameter int unsigned      SCAN_DIV   = 2,
   parameter logic [SEL_W-1:0] SEL_TENS   = '0,
   parameter logic [SEL_W-1:0] SEL_ONES   = '0,
   parameter bit               LEAD_BLANK = 1'b1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               clear_i,
   input logic [VALUE_W-1:0] value_i,
   input logic [6:0]         seg_o,
   input logic [SEL_W-1:0]   dig_sel_o
);
   localparam int unsigned CW = $clog2(SCAN_DIV + 1);

   logic          started;
   logic [CW-1:0] slot_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         started  <= 1'b0;
         slot_cnt <= '0;
      end else begin
         started  <= 1'b1;
         slot_cnt <= (clear_i || slot_cnt == CW'(SCAN_DIV - 1)) ? '0 : slot_cnt + 1'b1;
      end
   end

   assert_sel_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started |-> (dig_sel_o == SEL_TENS || dig_sel_o == SEL_ONES));

   assert_slot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started && !clear_i && slot_cnt != CW'(SCAN_DIV - 1)) |=> $stable(dig_sel_o));

   assert_clear_tens_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (dig_sel_o == SEL_TENS));

   assert_over_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started && $past(value_i) > VALUE_W'(99)) |-> (seg_o == 7'b000_0000));

   if (LEAD_BLANK) begin : g_lead
      assert_lead_dark_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (started && dig_sel_o == SEL_TENS && $past(value_i) < VALUE_W'(10))
            |-> (seg_o == 7'b000_0000));
   end
endmodule

bind dual_digit_display dual_digit_display_checker #(
   .VALUE_W    (VALUE_W),
   .SEL_W      (SEL_W),
   .SCAN_DIV   (SCAN_DIV),
   .SEL_TENS   (SEL_TENS),
   .SEL_ONES   (SEL_ONES),
   .LEAD_BLANK (LEAD_BLANK)
) i_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .clear_i   (clear_i),
   .value_i   (value_i),
   .seg_o     (seg_o),
   .dig_sel_o (dig_sel_o)
);

// File: tb/test_dual_digit_display.sv
module test_dual_digit_display;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 8;
   localparam logic [7:0] TENS_SEL = 8'b0000_0010;
   localparam logic [7:0] ONES_SEL = 8'b0000_0001;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clear = 1'b0;
   logic [7:0] value = 8'd0;
   logic [6:0] seg;
   logic [7:0] sel;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_digit_display #(.CLK_HZ(8000), .SCAN_HZ(1000)) i_dual_digit_display (
      .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .value_i(value),
      .seg_o(seg), .dig_sel_o(sel)
   );

   function automatic logic [6:0] glyph(input int d);
      logic [6:0] g [10] = '{7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001,
                             7'b0110011, 7'b1011011, 7'b0011111, 7'b1110000,
                             7'b1111111, 7'b1110011};
      return g[d];
   endfunction

   function automatic logic [6:0] exp_tens(input int v);
      if (v > 99 || v < 10) return 7'b0;
      return glyph(v / 10);
   endfunction

   function automatic logic [6:0] exp_ones(input int v);
      if (v > 99) return 7'b0;
      return glyph(v % 10);
   endfunction

   function automatic string tag_for(input int v, input bit tens_slot);
      if (v > 99) return "R6";
      if (tens_slot) return (v < 10) ? "R5" : "R3";
      return (v % 10 == 0) ? "R5" : "R2";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, expv);
      end
   endtask

   // clear aligns the scan, then two full slots are observed (R8, R9, R10, R4)
   task automatic show(input int v);
      @(negedge clk);
      value = v[7:0];
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      for (int i = 0; i < 2 * DIV; i++) begin
         bit tens_slot = (i < DIV);
         check(i == 0 ? "R9" : "R8", sel, tens_slot ? TENS_SEL : ONES_SEL);
         check(tag_for(v, tens_slot), seg, tens_slot ? exp_tens(v) : exp_ones(v));
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      int          directed [10] = '{0, 5, 9, 10, 42, 80, 90, 99, 100, 255};
      seed_dummy = $urandom(32'd2024);

      repeat (3) @(negedge clk);
      check("R1", {25'd0, seg}, 32'd0);
      check("R1", {24'd0, sel}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", {24'd0, sel}, {24'd0, TENS_SEL});

      foreach (directed[k]) show(directed[k]);

      // R4: every glyph in both slots
      for (int d = 0; d < 10; d++) show(d * 11);

      // R11 / R10: value changes inside the tens slot
      show(37);
      check("R11", {25'd0, seg}, {25'd0, exp_tens(37)});
      value = 8'd64;
      @(negedge clk);
      check("R11", {25'd0, seg}, {25'd0, exp_tens(64)});
      check("R10", {24'd0, sel}, {24'd0, TENS_SEL});

      // R9: clear from the middle of the ones slot
      while (sel != ONES_SEL) @(negedge clk);
      repeat (2) @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      check("R9", {24'd0, sel}, {24'd0, TENS_SEL});
      check("R9", {25'd0, seg}, {25'd0, exp_tens(64)});

      for (int n = 0; n < 40; n++) show(int'($urandom_range(0, 99)));
      for (int n = 0; n < 8; n++)  show(int'($urandom_range(100, 255)));

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule